// File: doc/BRIEF.md
# Status Write Engine for a One-Time-Programmable Byte Array

This block is the device-side byte engine for a status-write transaction on a single-wire serial memory. A bit-level front end hands it complete received bytes, read-slot requests, a programming-pulse strobe and an abort strobe. The engine recognises the status-write opcode and collects a two-byte address and a data byte. It then offers an 8-bit CRC for the host to read. After the host accepts the CRC, the engine waits for a program-control opcode and a programming pulse. On the pulse it clears bits in a small one-time-programmable status array. It then offers the programmed byte so the host can check it.

After each verify read the engine moves to the next address on its own. The host may then stream further data bytes, each with its own CRC, programming step and verify read. The engine never checks a CRC itself, so the host decides whether to go on. An abort strobe returns the engine to idle at any point. The stored status bytes survive the abort and are lost only on the chip reset.

Top module: `otp_wstat_engine`

## Requirements
- R1: In idle, only the received byte 55h starts a transaction. Any other byte leaves the engine idle, and read slots then return 1 bits.
- R2: Every outbound byte is sent least significant bit first. `tx_bit` shows the bit on offer, and each `rd_req` while `tx_active` is high moves to the next bit. While `tx_active` is low, `tx_bit` is 1.
- R3: The first CRC starts from 00h and takes in the opcode, the address low byte, the address high byte and the data byte, in that order. Each bit is shifted LSB first with the polynomial x^8+x^5+x^4+1, in the shift-right form with constant 8Ch.
- R4: After the eight CRC slots, a received 5Ah arms programming. Any other byte returns the engine to idle, and a later pulse then changes nothing.
- R5: An armed pulse replaces the addressed byte with the old value ANDed with the data byte. Bytes 0 to DEPTH-2 start as FFh after chip reset.
- R6: The last byte of the array (index DEPTH-1) always reads 00h.
- R7: After the pulse, eight slots return the stored byte at the current address. After the eighth slot the address always goes up by one.
- R8: For each later data byte, the CRC register is loaded with the new address low byte, and then only that data byte is shifted in.
- R9: `bus_reset` returns the engine to idle from any state. It drops `tx_active` on the next cycle and leaves the array unchanged.
- R10: An address of DEPTH or above, compared on all 16 bits, is never programmed. Its verify read returns FFh, and the address still goes up by one.
- R11: A `prog_pulse` that comes while programming is not armed has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous; also restores the array |
| bus_reset | input | 1 | Abort strobe from the front end |
| rx_valid | input | 1 | A received byte is present on `rx_byte` for this cycle |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | The host has consumed one read slot |
| prog_pulse | input | 1 | Programming pulse has been applied |
| tx_bit | output | 1 | Bit currently offered to the host |
| tx_active | output | 1 | An outbound byte is being offered |

## Verification
Single writes sweep every address from 0 to 9 in several passes. A walking-zero pattern shows that each bit clears on its own. A second, denser pattern shows that earlier zeros stay cleared. An all-ones pass shows that nothing can be set back to 1, and it also separates the fixed last byte and the out-of-range addresses from the writable ones. One long streamed transaction runs across the end of the array, which tells the loaded-seed CRC apart from a shifted one and shows the address advancing past the array. Further runs send a wrong program-control byte, a stray pulse, an abort during a CRC read and a nonzero address high byte. After each of these, a probe write with data FFh reads the stored byte back, so a change that should not have happened shows up.

// File: rtl/otp_wstat_pkg.sv
package otp_wstat_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 16;

    localparam logic [BYTE_W-1:0] OP_WRITE_STATUS = 8'h55;
    localparam logic [BYTE_W-1:0] OP_PROG_CTRL    = 8'h5A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR_LO,
        ST_ADR_HI,
        ST_DATA,
        ST_CRC_TX,
        ST_ARM,
        ST_PULSE,
        ST_VFY_TX
    } wst_state_e;

endpackage

// File: rtl/otp_crc8_unit.sv
// Folds one byte into an LSB-first CRC-8 in a single combinational pass.
module otp_crc8_unit #(
    parameter int unsigned         W    = 8,
    parameter logic [W-1:0]        POLY = 8'h8C
) (
    input  logic [W-1:0] seed,
    input  logic [W-1:0] din,
    output logic [W-1:0] result
);

    logic [W-1:0] chain [0:W];

    assign chain[0] = seed;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic fb;
        assign fb           = chain[g][0] ^ din[g];
        assign chain[g + 1] = {1'b0, chain[g][W-1:1]} ^ (fb ? POLY : '0);
    end

    assign result = chain[W];

endmodule

// File: rtl/otp_status_array.sv
// One-time-programmable status cells: bits can only be cleared; last entry tied low.
module otp_status_array #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [W-1:0]         wr_data,
    output logic [DEPTH*W-1:0]   flat
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i == DEPTH - 1) begin : g_fixed
            assign flat[i*W +: W] = '0;
        end else begin : g_prog
            logic [W-1:0] cell_d, cell_q;

            always_comb begin
                cell_d = cell_q;
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    cell_d = cell_q & wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= '1;
                end else begin
                    cell_q <= cell_d;
                end
            end

            assign flat[i*W +: W] = cell_q;
        end
    end

endmodule

// File: rtl/otp_tx_shifter.sv
// Offers one byte bit by bit, LSB first, advancing once per consumed read slot.
module otp_tx_shifter #(
    parameter int unsigned W = 8,
    localparam int unsigned CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         line_bit,
    output logic         active,
    output logic         done
);

    typedef struct packed {
        logic [W-1:0]     sh;
        logic [CNT_W-1:0] cnt;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (clear) begin
            shf_d.cnt = '0;
        end else if (load) begin
            shf_d.sh  = load_val;
            shf_d.cnt = CNT_W'(W);
        end else if (shift && (shf_q.cnt != '0)) begin
            shf_d.sh  = {1'b1, shf_q.sh[W-1:1]};
            shf_d.cnt = shf_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign active   = (shf_q.cnt != '0);
    assign line_bit = active ? shf_q.sh[0] : 1'b1;
    assign done     = !clear && shift && (shf_q.cnt == CNT_W'(1));

endmodule

// File: rtl/otp_wstat_engine.sv
module otp_wstat_engine
    import otp_wstat_pkg::*;
#(
    parameter int unsigned       DEPTH    = 8,
    parameter logic [BYTE_W-1:0] CRC_POLY = 8'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rd_req,
    input  logic              prog_pulse,
    output logic              tx_bit,
    output logic              tx_active
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    typedef struct packed {
        wst_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] crc;
        logic [BYTE_W-1:0] data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [BYTE_W-1:0]       crc_seed, crc_out;
    logic [DEPTH*BYTE_W-1:0] stat_flat;
    logic [BYTE_W-1:0]       cur_byte;
    logic                    in_range;
    logic                    pulse_armed;
    logic                    wr_en;
    logic                    tx_load;
    logic [BYTE_W-1:0]       tx_val;
    logic                    tx_done;

    // The opcode starts a fresh CRC; every later byte continues the register.
    assign crc_seed = (eng_q.st == ST_IDLE) ? '0 : eng_q.crc;

    otp_crc8_unit #(
        .W    (BYTE_W),
        .POLY (CRC_POLY)
    ) u_crc (
        .seed   (crc_seed),
        .din    (rx_byte),
        .result (crc_out)
    );

    assign in_range    = (eng_q.addr < DEPTH_A);
    assign pulse_armed = (eng_q.st == ST_PULSE);
    assign cur_byte    = in_range ? stat_flat[eng_q.addr[IDX_W-1:0]*BYTE_W +: BYTE_W] : '1;

    always_comb begin
        eng_d   = eng_q;
        wr_en   = 1'b0;
        tx_load = 1'b0;
        tx_val  = '1;
        if (bus_reset) begin
            eng_d.st = ST_IDLE;
        end else begin
            unique case (eng_q.st)
                ST_IDLE: begin
                    if (rx_valid && (rx_byte == OP_WRITE_STATUS)) begin
                        eng_d.crc = crc_out;
                        eng_d.st  = ST_ADR_LO;
                    end
                end
                ST_ADR_LO: begin
                    if (rx_valid) begin
                        eng_d.addr[7:0] = rx_byte;
                        eng_d.crc       = crc_out;
                        eng_d.st        = ST_ADR_HI;
                    end
                end
                ST_ADR_HI: begin
                    if (rx_valid) begin
                        eng_d.addr[ADDR_W-1:8] = rx_byte;
                        eng_d.crc              = crc_out;
                        eng_d.st               = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (rx_valid) begin
                        eng_d.data = rx_byte;
                        eng_d.crc  = crc_out;
                        eng_d.st   = ST_CRC_TX;
                        tx_load    = 1'b1;
                        tx_val     = crc_out;
                    end
                end
                ST_CRC_TX: begin
                    if (tx_done) begin
                        eng_d.st = ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (rx_valid) begin
                        eng_d.st = (rx_byte == OP_PROG_CTRL) ? ST_PULSE : ST_IDLE;
                    end
                end
                ST_PULSE: begin
                    if (prog_pulse) begin
                        wr_en    = in_range;
                        tx_load  = 1'b1;
                        tx_val   = in_range ? (cur_byte & eng_q.data) : '1;
                        eng_d.st = ST_VFY_TX;
                    end
                end
                ST_VFY_TX: begin
                    if (tx_done) begin
                        eng_d.addr = eng_q.addr + ADDR_W'(1);
                        eng_d.crc  = eng_d.addr[7:0];
                        eng_d.st   = ST_DATA;
                    end
                end
                default: eng_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, addr: '0, crc: '0, data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    otp_status_array #(
        .DEPTH (DEPTH),
        .W     (BYTE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && pulse_armed),
        .wr_idx  (eng_q.addr[IDX_W-1:0]),
        .wr_data (eng_q.data),
        .flat    (stat_flat)
    );

    otp_tx_shifter #(
        .W (BYTE_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (bus_reset),
        .load     (tx_load),
        .load_val (tx_val),
        .shift    (rd_req),
        .line_bit (tx_bit),
        .active   (tx_active),
        .done     (tx_done)
    );

endmodule

// File: rtl/otp_wstat_checker.sv
module otp_wstat_checker #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_reset,
    input logic               prog_pulse,
    input logic               pulse_armed,
    input logic               tx_bit,
    input logic               tx_active,
    input logic [DEPTH*W-1:0] stat_flat
);

    // Line idles high whenever no byte is on offer.
    assert_idle_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_bit);

    // An abort drops any outbound byte on the next cycle.
    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !tx_active);

    // Once cleared, a stored bit never returns to one.
    assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(stat_flat) & stat_flat) == '0));

    // The last entry reads zero at all times.
    assert_fixed_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flat[(DEPTH-1)*W +: W] == '0);

    // Without an armed, unaborted pulse the array holds still.
    assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_armed && prog_pulse && !bus_reset) |=> $stable(stat_flat));

    // An armed pulse always leads to the verify byte being offered.
    assert_pulse_verify_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_armed && prog_pulse && !bus_reset) |=> tx_active);

endmodule

bind otp_wstat_engine otp_wstat_checker #(
    .DEPTH (DEPTH),
    .W     (otp_wstat_pkg::BYTE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset   (bus_reset),
    .prog_pulse  (prog_pulse),
    .pulse_armed (pulse_armed),
    .tx_bit      (tx_bit),
    .tx_active   (tx_active),
    .stat_flat   (stat_flat)
);

// File: tb/otp_wstat_engine_tb.sv
module otp_wstat_engine_tb;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic       prog_pulse = 1'b0;
    logic       tx_bit;
    logic       tx_active;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] model [0:DEPTH-1];

    always #2 clk = ~clk;

    otp_wstat_engine #(.DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rd_req     (rd_req),
        .prog_pulse (prog_pulse),
        .tx_bit     (tx_bit),
        .tx_active  (tx_active)
    );

    function automatic logic [7:0] crc_fold(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            b[i]   = tx_bit;
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        prog_pulse = 1'b1;
        @(negedge clk);
        prog_pulse = 1'b0;
    endtask

    task automatic abort();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    function automatic logic [7:0] model_prog(input logic [15:0] a, input logic [7:0] d);
        if (a < DEPTH) begin
            model[a] = model[a] & d;
            return model[a];
        end
        return 8'hFF;
    endfunction

    // Full single-byte write with CRC and verify checks.
    task automatic write_one(input logic [15:0] a, input logic [7:0] d, input string tag);
        logic [7:0] got;
        logic [7:0] exp;
        send(8'h55); send(a[7:0]); send(a[15:8]); send(d);
        exp = crc_fold(crc_fold(crc_fold(crc_fold(8'h00, 8'h55), a[7:0]), a[15:8]), d);
        read_byte(got);
        chk({"R3 R2 first crc ", tag}, got, exp);
        send(8'h5A);
        pulse();
        exp = model_prog(a, d);
        read_byte(got);
        chk({"R5 R6 R7 R10 verify ", tag}, got, exp);
        abort();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic [7:0] exp;
        for (int i = 0; i < DEPTH; i++) model[i] = (i == DEPTH - 1) ? 8'h00 : 8'hFF;

        repeat (3) @(negedge clk);
        chk("reset tx_active", {7'd0, tx_active}, 8'h00);
        chk("R2 reset line high", {7'd0, tx_bit}, 8'h01);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: foreign opcodes leave the engine idle.
        send(8'hA5); send(8'h00); send(8'h12); send(8'h34);
        @(negedge clk);
        chk("R1 no start on A5", {7'd0, tx_active}, 8'h00);
        read_byte(got);
        chk("R1 R2 idle slots read ones", got, 8'hFF);

        // Sweep passes over every address and a few beyond.
        for (int a = 0; a < DEPTH + 2; a++)
            write_one(16'(a), ~(8'h01 << (a % 8)), "walk0");
        for (int a = 0; a < DEPTH + 2; a++)
            write_one(16'(a), 8'h5A ^ 8'(a * 17), "dense");
        for (int a = 0; a < DEPTH + 2; a++)
            write_one(16'(a), 8'hFF, "ones");

        // R10: nonzero high byte is out of range, low byte alias untouched.
        write_one(16'h0100, 8'h00, "hi-byte");
        write_one(16'h0000, 8'hFF, "alias probe");

        // R7 R8 R10: streamed transaction across the array end.
        begin
            logic [15:0] a = 16'd4;
            logic [7:0]  d = 8'hF0;
            send(8'h55); send(a[7:0]); send(a[15:8]); send(d);
            exp = crc_fold(crc_fold(crc_fold(crc_fold(8'h00, 8'h55), a[7:0]), a[15:8]), d);
            read_byte(got);
            chk("R3 stream first crc", got, exp);
            for (int k = 0; k < 6; k++) begin
                send(8'h5A);
                pulse();
                exp = model_prog(a, d);
                read_byte(got);
                chk("R7 R10 stream verify", got, exp);
                a = a + 16'd1;
                d = 8'(8'h3C + k * 29);
                send(d);
                read_byte(got);
                chk("R8 stream reseeded crc", got, crc_fold(a[7:0], d));
            end
            abort();
        end

        // R4: wrong program-control byte returns to idle; pulse does nothing.
        send(8'h55); send(8'h02); send(8'h00); send(8'h00);
        read_byte(got);
        send(8'h33);
        pulse();
        @(negedge clk);
        chk("R4 idle after wrong control", {7'd0, tx_active}, 8'h00);
        write_one(16'h0002, 8'hFF, "R4 probe");

        // R11: pulse before the CRC is read, and in idle, is ignored.
        pulse();
        send(8'h55); send(8'h01); send(8'h00);
        pulse();
        send(8'h00);
        read_byte(got);
        chk("R11 R3 crc unaffected",
            got, crc_fold(crc_fold(crc_fold(crc_fold(8'h00, 8'h55), 8'h01), 8'h00), 8'h00));
        abort();
        write_one(16'h0001, 8'hFF, "R11 probe");

        // R9: abort mid-CRC, and abort after arming.
        send(8'h55); send(8'h03); send(8'h00); send(8'h00);
        @(negedge clk); rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        abort();
        @(negedge clk);
        chk("R9 abort drops tx", {7'd0, tx_active}, 8'h00);
        send(8'h55); send(8'h03); send(8'h00); send(8'h00);
        read_byte(got);
        send(8'h5A);
        abort();
        pulse();
        write_one(16'h0003, 8'hFF, "R9 probe");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule